// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core with Sign Branch and Upper Immediate

This block is a small 32-bit processor that finishes one instruction on every clock edge. A program counter addresses a built-in instruction ROM. A two-read, one-write register file feeds an ALU, and the result goes back to the register file or to a word-addressed data RAM. The instruction set covers register add, subtract, and, or and signed set-less-than, plus add-immediate, word load and store, branch-on-equal and absolute jump.

Two instructions extend the base set. The first loads an upper immediate: it places the 16-bit immediate in the top half of the destination and clears the bottom half. The second is a branch on the sign bit. It shares an opcode with other register-immediate forms and is picked out by the rt field. It branches when the source register, read as a signed value, is zero or positive, and it never writes a register.

The decoder sorts each word into one of nine instruction kinds: `K_RTYPE`, `K_LOAD`, `K_STORE`, `K_BEQ`, `K_ADDI`, `K_JUMP`, `K_LUI`, `K_BGEZ` and `K_NOP`. Each kind maps to a fixed control word. There is no sequencing state. The only stored state is the program counter, which moves each cycle along one of three edges: `SEQ` (PC+4), `BRANCH` (branch target) or `JUMP` (jump target). Architectural writes are brought out on ports so that the core can be observed.

Top module: `scx_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 on that edge.
- R2: Every instruction that is not a taken branch or a jump advances the PC by 4. The PC always stays word aligned.
- R3: Register-register words (opcode 000000) write rd (bits 15:11). The funct field selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 set-less-than, with set-less-than comparing as signed.
- R4: Add-immediate (opcode 001000) writes rt (bits 20:16) with rs plus the sign-extended 16-bit immediate.
- R5: Load word (opcode 100011) writes rt with the data word at byte address rs plus the sign-extended immediate. Store word (opcode 101011) writes rt to that address and writes no register.
- R6: Branch-on-equal (opcode 000100) goes to PC+4 plus the sign-extended immediate shifted left by 2 when rs equals rt, and to PC+4 otherwise.
- R7: Jump (opcode 000010) goes to {PC+4[31:28], instr[25:0], 2'b00}.
- R8: Upper-immediate load (opcode 001111) writes rt with {instr[15:0], 16'h0000}.
- R9: Sign branch (opcode 000001 with rt field 00001) goes to the branch target of R6 when bit 31 of rs is 0, which includes rs equal to zero, and to PC+4 when it is 1. It writes no register.
- R10: Register 0 reads as zero. Writes to register 0 are ignored, so a later store of register 0 stores 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Current program counter (byte address) |
| rf_we_o | output | 1 | Register write enable of the instruction being executed |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value written to the destination register |
| mem_we_o | output | 1 | Data RAM write strobe |
| mem_addr_o | output | 32 | Data RAM byte address (ALU result) |
| mem_wdata_o | output | 32 | Data RAM write data (rt value) |

## Verification
The core has no buffering, so a wrong internal value shows up on the ports within one or two cycles. A bad decode or ALU result appears in the same cycle on the register-write or store ports. A wrong next-PC choice appears on `pc_o` at the very next edge. A register value that was written wrongly or wrongly suppressed appears as soon as a later instruction reads it. A behavioural instruction-level model in the bench follows the design clock by clock. It compares the PC and every write port each cycle, so a divergence is reported in the cycle it first becomes visible. Fixed-value checks cover the sign-branch cases (negative, zero and positive source) and the full 32-bit upper-immediate result.

// File: rtl/scx_pkg.sv
package scx_pkg;

    localparam logic [5:0] OP_RTYPE  = 6'b000000;
    localparam logic [5:0] OP_REGIMM = 6'b000001;
    localparam logic [5:0] OP_JUMP   = 6'b000010;
    localparam logic [5:0] OP_BEQ    = 6'b000100;
    localparam logic [5:0] OP_ADDI   = 6'b001000;
    localparam logic [5:0] OP_LUI    = 6'b001111;
    localparam logic [5:0] OP_LOAD   = 6'b100011;
    localparam logic [5:0] OP_STORE  = 6'b101011;

    localparam logic [4:0] RT_BGEZ = 5'b00001;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [3:0] {
        K_NOP, K_RTYPE, K_LOAD, K_STORE, K_BEQ,
        K_ADDI, K_JUMP, K_LUI, K_BGEZ
    } insn_kind_e;

    // base control word keeps the classic ordering; two extra flags follow
    typedef struct packed {
        logic       regwrite;
        logic       regdst;
        logic       alusrc;
        logic       branch;
        logic       memwrite;
        logic       memtoreg;
        logic       jump;
        logic [1:0] aluop;
        logic       upper;
        logic       signbr;
    } ctrl_t;

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {OP_RTYPE, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] idx);
        return {OP_JUMP, idx};
    endfunction

endpackage

// File: rtl/scx_decode.sv
module scx_decode
    import scx_pkg::*;
(
    input  logic [5:0] op,
    input  logic [4:0] rt_f,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_op_e    alu_sel
);

    insn_kind_e kind;

    always_comb begin
        kind = K_NOP;
        unique case (op)
            OP_RTYPE:  kind = K_RTYPE;
            OP_LOAD:   kind = K_LOAD;
            OP_STORE:  kind = K_STORE;
            OP_BEQ:    kind = K_BEQ;
            OP_ADDI:   kind = K_ADDI;
            OP_JUMP:   kind = K_JUMP;
            OP_LUI:    kind = K_LUI;
            OP_REGIMM: kind = (rt_f == RT_BGEZ) ? K_BGEZ : K_NOP;
            default:   kind = K_NOP;
        endcase
    end

    always_comb begin
        ctrl = '0;
        unique case (kind)
            K_RTYPE: ctrl = ctrl_t'({9'b110000010, 2'b00});
            K_LOAD:  ctrl = ctrl_t'({9'b101001000, 2'b00});
            K_STORE: ctrl = ctrl_t'({9'b001010000, 2'b00});
            K_BEQ:   ctrl = ctrl_t'({9'b000100001, 2'b00});
            K_ADDI:  ctrl = ctrl_t'({9'b101000000, 2'b00});
            K_JUMP:  ctrl = ctrl_t'({9'b000000100, 2'b00});
            K_LUI:   ctrl = ctrl_t'({9'b101000000, 2'b10});
            K_BGEZ:  ctrl = ctrl_t'({9'b000000000, 2'b01});
            K_NOP:   ctrl = '0;
            default: ctrl = '0;
        endcase
    end

    always_comb begin
        alu_sel = ALU_ADD;
        unique case (ctrl.aluop)
            2'b00: alu_sel = ALU_ADD;
            2'b01: alu_sel = ALU_SUB;
            default: begin
                unique case (funct)
                    FN_ADD:  alu_sel = ALU_ADD;
                    FN_SUB:  alu_sel = ALU_SUB;
                    FN_AND:  alu_sel = ALU_AND;
                    FN_OR:   alu_sel = ALU_OR;
                    FN_SLT:  alu_sel = ALU_SLT;
                    default: alu_sel = ALU_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/scx_alu.sv
module scx_alu
    import scx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      sel,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        y = a + b;
        unique case (sel)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scx_regfile.sv
module scx_regfile #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/scx_mem.sv
module scx_rom
    import scx_pkg::*;
#(
    parameter int WORDS = 32,
    localparam int IAW  = $clog2(WORDS)
) (
    input  logic [31:0] addr,
    output logic [31:0] data
);

    function automatic logic [31:0] prog_word(input int idx);
        case (idx)
            0:  return enc_i(OP_ADDI, 5'd0, 5'd1, 16'd7);
            1:  return enc_i(OP_ADDI, 5'd0, 5'd2, 16'hFFFD);
            2:  return enc_r(5'd1, 5'd2, 5'd3, FN_ADD);
            3:  return enc_r(5'd2, 5'd1, 5'd4, FN_SUB);
            4:  return enc_r(5'd1, 5'd3, 5'd5, FN_AND);
            5:  return enc_r(5'd1, 5'd4, 5'd6, FN_OR);
            6:  return enc_r(5'd2, 5'd1, 5'd7, FN_SLT);
            7:  return enc_i(OP_LUI, 5'd0, 5'd8, 16'h8001);
            8:  return enc_i(OP_REGIMM, 5'd4, RT_BGEZ, 16'd3);
            9:  return enc_i(OP_STORE, 5'd0, 5'd8, 16'd4);
            10: return enc_i(OP_REGIMM, 5'd1, RT_BGEZ, 16'd1);
            11: return enc_i(OP_ADDI, 5'd0, 5'd9, 16'd99);
            12: return enc_i(OP_LOAD, 5'd0, 5'd10, 16'd4);
            13: return enc_i(OP_BEQ, 5'd10, 5'd8, 16'd1);
            14: return enc_i(OP_ADDI, 5'd0, 5'd9, 16'd55);
            15: return enc_r(5'd10, 5'd6, 5'd11, FN_ADD);
            16: return enc_i(OP_REGIMM, 5'd0, RT_BGEZ, 16'd1);
            17: return enc_i(OP_ADDI, 5'd0, 5'd9, 16'd1);
            18: return enc_i(OP_BEQ, 5'd1, 5'd2, 16'd5);
            19: return enc_i(OP_ADDI, 5'd0, 5'd0, 16'd5);
            20: return enc_i(OP_STORE, 5'd0, 5'd0, 16'd8);
            21: return enc_i(OP_STORE, 5'd0, 5'd11, 16'd84);
            22: return enc_j(26'd22);
            default: return 32'h0;
        endcase
    endfunction

    logic [IAW-1:0] idx;
    logic           unused_rom;

    assign idx        = addr[IAW+1:2];
    assign data       = (int'(idx) < WORDS) ? prog_word(int'(idx)) : 32'h0;
    assign unused_rom = ^{addr[31:IAW+2], addr[1:0]};

endmodule

module scx_dram #(
    parameter int WORDS = 64,
    localparam int DAW  = $clog2(WORDS)
) (
    input  logic        clk,
    input  logic        we,
    input  logic [31:0] addr,
    input  logic [31:0] wd,
    output logic [31:0] rd
);

    logic [31:0]    mem [WORDS];
    logic [DAW-1:0] idx;
    logic           unused_dram;

    assign idx         = addr[DAW+1:2];
    assign rd          = mem[idx];
    assign unused_dram = ^{addr[31:DAW+2], addr[1:0]};

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wd;
    end

endmodule

// File: rtl/scx_core.sv
module scx_core
    import scx_pkg::*;
#(
    parameter int IMEM_WORDS = 32,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] pc_o,
    output logic        rf_we_o,
    output logic [4:0]  rf_waddr_o,
    output logic [31:0] rf_wdata_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o
);

    typedef enum logic [1:0] { SEQ, BRANCH, JUMP } pc_edge_e;

    logic [31:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [31:0] instr, imm_sext, rs_val, rt_val, alu_b, alu_y, rd_data, wb_data;
    logic [4:0]  waddr;
    logic        alu_zero, take_br, unused_core;
    ctrl_t       ctrl;
    alu_op_e     alu_sel;
    pc_edge_e    pc_edge;

    scx_rom #(.WORDS(IMEM_WORDS)) u_rom (.addr(pc_q), .data(instr));

    scx_decode u_dec (
        .op(instr[31:26]), .rt_f(instr[20:16]), .funct(instr[5:0]),
        .ctrl(ctrl), .alu_sel(alu_sel)
    );

    scx_regfile #(.W(32), .NREGS(32)) u_rf (
        .clk(clk), .rst(rst),
        .ra1(instr[25:21]), .ra2(instr[20:16]),
        .rd1(rs_val), .rd2(rt_val),
        .we(ctrl.regwrite), .wa(waddr), .wd(wb_data)
    );

    scx_alu #(.W(32)) u_alu (
        .a(rs_val), .b(alu_b), .sel(alu_sel), .y(alu_y), .zero(alu_zero)
    );

    scx_dram #(.WORDS(DMEM_WORDS)) u_dram (
        .clk(clk), .we(ctrl.memwrite), .addr(alu_y), .wd(rt_val), .rd(rd_data)
    );

    assign imm_sext = {{16{instr[15]}}, instr[15:0]};
    assign alu_b    = ctrl.alusrc ? imm_sext : rt_val;
    assign waddr    = ctrl.regdst ? instr[15:11] : instr[20:16];

    always_comb begin
        if (ctrl.upper)         wb_data = {instr[15:0], 16'h0000};
        else if (ctrl.memtoreg) wb_data = rd_data;
        else                    wb_data = alu_y;
    end

    assign pc_plus4   = pc_q + 32'd4;
    assign br_target  = pc_plus4 + {imm_sext[29:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_br    = (ctrl.branch & alu_zero) | (ctrl.signbr & ~rs_val[31]);

    always_comb begin
        if (ctrl.jump)    pc_edge = JUMP;
        else if (take_br) pc_edge = BRANCH;
        else              pc_edge = SEQ;
    end

    always_comb begin
        pc_next = pc_plus4;
        unique case (pc_edge)
            SEQ:     pc_next = pc_plus4;
            BRANCH:  pc_next = br_target;
            JUMP:    pc_next = jmp_target;
            default: pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign unused_core = ^instr[10:6];

    assign pc_o        = pc_q;
    assign rf_we_o     = ctrl.regwrite;
    assign rf_waddr_o  = waddr;
    assign rf_wdata_o  = wb_data;
    assign mem_we_o    = ctrl.memwrite;
    assign mem_addr_o  = alu_y;
    assign mem_wdata_o = rt_val;

endmodule

// File: rtl/scx_core_chk.sv
module scx_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic        rf_we_o,
    input logic [4:0]  rf_waddr_o,
    input logic [31:0] rf_wdata_o,
    input logic        mem_we_o
);

    logic        is_bgez, is_lui;
    logic [31:0] exp_br, exp_seq;

    assign is_bgez = (instr[31:26] == 6'b000001) && (instr[20:16] == 5'b00001);
    assign is_lui  = (instr[31:26] == 6'b001111);
    assign exp_seq = pc_o + 32'd4;
    assign exp_br  = exp_seq + {{14{instr[15]}}, instr[15:0], 2'b00};

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> (pc_o == 32'd0));

    // R2
    pc_align_chk: assert property (@(posedge clk) disable iff (rst) pc_o[1:0] == 2'b00);

    // R8
    lui_write_chk: assert property (@(posedge clk) disable iff (rst)
        is_lui |-> (rf_we_o && rf_waddr_o == instr[20:16] && rf_wdata_o == {instr[15:0], 16'h0}));

    // R9
    bgez_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (is_bgez && !rs_val[31]) |=> (pc_o == $past(exp_br)));

    // R9
    bgez_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (is_bgez && rs_val[31]) |=> (pc_o == $past(exp_seq)));

    // R9
    bgez_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        is_bgez |-> (!rf_we_o && !mem_we_o));

    // R5
    store_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> !rf_we_o);

endmodule

bind scx_core scx_core_chk u_chk (
    .clk(clk), .rst(rst), .pc_o(pc_o), .instr(instr), .rs_val(rs_val),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .mem_we_o(mem_we_o)
);

// File: tb/scx_core_tb.sv
`timescale 1ns/1ps
module scx_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o, rf_wdata_o, mem_addr_o, mem_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, mem_we_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    scx_core u_dut (
        .clk(clk), .rst(rst), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    // behavioural model state
    logic [31:0] m_pc;
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [64];
    logic        e_rwe, e_mwe;
    logic [4:0]  e_rwa;
    logic [31:0] e_rwd, e_ma, e_md, e_npc;
    string       e_tag;

    function automatic logic [31:0] wI(int op, int rs, int rt, int imm);
        return (32'(op) << 26) | (32'(rs) << 21) | (32'(rt) << 16) | (32'(imm) & 32'hFFFF);
    endfunction

    function automatic logic [31:0] wR(int rs, int rt, int rd, int fn);
        return (32'(rs) << 21) | (32'(rt) << 16) | (32'(rd) << 11) | 32'(fn);
    endfunction

    function automatic logic [31:0] program_at(int i);
        case (i)
            0:  return wI(8, 0, 1, 7);
            1:  return wI(8, 0, 2, -3);
            2:  return wR(1, 2, 3, 32);
            3:  return wR(2, 1, 4, 34);
            4:  return wR(1, 3, 5, 36);
            5:  return wR(1, 4, 6, 37);
            6:  return wR(2, 1, 7, 42);
            7:  return wI(15, 0, 8, 32'h8001);
            8:  return wI(1, 4, 1, 3);
            9:  return wI(43, 0, 8, 4);
            10: return wI(1, 1, 1, 1);
            11: return wI(8, 0, 9, 99);
            12: return wI(35, 0, 10, 4);
            13: return wI(4, 10, 8, 1);
            14: return wI(8, 0, 9, 55);
            15: return wR(10, 6, 11, 32);
            16: return wI(1, 0, 1, 1);
            17: return wI(8, 0, 9, 1);
            18: return wI(4, 1, 2, 5);
            19: return wI(8, 0, 0, 5);
            20: return wI(43, 0, 0, 8);
            21: return wI(43, 0, 11, 84);
            22: return (32'd2 << 26) | 32'd22;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_eval();
        logic [31:0] w, a, b, simm, p4;
        int op, rs, rt, rd, fn;
        w = program_at(int'(m_pc >> 2));
        op = int'(w >> 26); rs = int'((w >> 21) & 31); rt = int'((w >> 16) & 31);
        rd = int'((w >> 11) & 31); fn = int'(w & 63);
        a = m_reg[rs]; b = m_reg[rt];
        simm = {{16{w[15]}}, w[15:0]};
        p4 = m_pc + 4;
        e_rwe = 0; e_mwe = 0; e_rwa = 0; e_rwd = 0; e_ma = 0; e_md = 0; e_npc = p4;
        e_tag = "R2";
        case (op)
            0: begin
                e_tag = "R3"; e_rwe = 1; e_rwa = 5'(rd);
                case (fn)
                    32: e_rwd = a + b;
                    34: e_rwd = a - b;
                    36: e_rwd = a & b;
                    37: e_rwd = a | b;
                    42: e_rwd = ($signed(a) < $signed(b)) ? 1 : 0;
                    default: e_rwd = a + b;
                endcase
            end
            8:  begin e_tag = "R4"; e_rwe = 1; e_rwa = 5'(rt); e_rwd = a + simm; end
            35: begin e_tag = "R5"; e_rwe = 1; e_rwa = 5'(rt); e_ma = a + simm;
                      e_rwd = m_mem[(e_ma >> 2) & 63]; end
            43: begin e_tag = "R5"; e_mwe = 1; e_ma = a + simm; e_md = b; end
            4:  begin e_tag = "R6"; if (a == b) e_npc = p4 + (simm << 2); end
            2:  begin e_tag = "R7"; e_npc = {p4[31:28], w[25:0], 2'b00}; end
            15: begin e_tag = "R8"; e_rwe = 1; e_rwa = 5'(rt); e_rwd = {w[15:0], 16'h0}; end
            1:  begin e_tag = "R9"; if (rt == 1 && !a[31]) e_npc = p4 + (simm << 2); end
            default: ;
        endcase
    endtask

    task automatic model_step();
        if (e_rwe && e_rwa != 0) m_reg[e_rwa] = e_rwd;
        if (e_mwe) m_mem[(e_ma >> 2) & 63] = e_md;
        m_pc = e_npc;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (pc=%h)", tag, act, exp, pc_o);
        end
    endtask

    task automatic compare_ports();
        chk({e_tag, " pc"}, pc_o, m_pc);
        chk({e_tag, " rf_we"}, 32'(rf_we_o), 32'(e_rwe));
        if (e_rwe) begin
            chk({e_tag, " rf_waddr"}, 32'(rf_waddr_o), 32'(e_rwa));
            chk({e_tag, " rf_wdata"}, rf_wdata_o, e_rwd);
        end
        chk({e_tag, " mem_we"}, 32'(mem_we_o), 32'(e_mwe));
        if (e_mwe) begin
            chk({e_tag, " mem_addr"}, mem_addr_o, e_ma);
            chk({e_tag, " mem_wdata"}, mem_wdata_o, e_md);
        end
    endtask

    task automatic fixed_now(int idx);
        case (idx)
            1:  chk("R4 negative imm", rf_wdata_o, 32'hFFFFFFFD);
            5:  chk("R3 or", rf_wdata_o, 32'hFFFFFFF7);
            6:  chk("R3 signed slt", rf_wdata_o, 32'd1);
            7:  begin chk("R8 lui data", rf_wdata_o, 32'h80010000);
                      chk("R8 lui dest", 32'(rf_waddr_o), 32'd8); end
            8:  chk("R9 no reg write", 32'(rf_we_o), 32'd0);
            9:  chk("R5 store data", mem_wdata_o, 32'h80010000);
            12: chk("R5 load data", rf_wdata_o, 32'h80010000);
            19: chk("R10 write to r0 dest", 32'(rf_waddr_o), 32'd0);
            20: chk("R10 r0 stays zero", mem_wdata_o, 32'd0);
            21: begin chk("R5 final store addr", mem_addr_o, 32'd84);
                      chk("R5 final store data", mem_wdata_o, 32'h8000FFF7); end
            default: ;
        endcase
    endtask

    task automatic fixed_next(int prev);
        case (prev)
            0:  chk("R2 sequential", pc_o, 32'd4);
            8:  chk("R9 negative not taken", pc_o, 32'd36);
            10: chk("R9 positive taken", pc_o, 32'd48);
            13: chk("R6 equal taken", pc_o, 32'd60);
            16: chk("R9 zero taken", pc_o, 32'd72);
            18: chk("R6 unequal not taken", pc_o, 32'd76);
            22: chk("R7 jump", pc_o, 32'd88);
            default: ;
        endcase
    endtask

    initial begin
        int prev;
        m_pc = 0;
        for (int i = 0; i < 32; i++) m_reg[i] = 0;
        for (int i = 0; i < 64; i++) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset pc", pc_o, 32'd0);
        rst = 1'b0;
        prev = -1;
        for (int c = 0; c < 40; c++) begin
            if (prev >= 0) fixed_next(prev);
            model_eval();
            compare_ports();
            fixed_now(int'(pc_o >> 2));
            prev = int'(pc_o >> 2);
            model_step();
            @(negedge clk);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule